// File: doc/BRIEF.md
# Cylinder Buffer Seek and Reload Controller

This block keeps one whole cylinder of an emulated disk, every head's track, in a local word buffer, so that a head change only moves the read and write index to another region of that buffer. The drive-side logic reads and writes the buffer through a head/word port. Each write marks that head's track as modified.

A seek command carries a target cylinder number and is carried out entirely by this block. First it copies every modified track of the current cylinder back to a backing memory, one 32-bit word at a time. Then it fetches every track of the target cylinder into the buffer. When the last word has arrived it pulses a completion flag and raises ready. The backing memory is reached through a simple word-addressed request/acknowledge port.

Disk geometry is configured at run time: image base address, cylinder count, head count and words per track.

Top module: `cylbuf_seek_ctrl`

## Requirements
- R1: After reset, `busy`, `ready`, `mem_req`, `seek_done` and `seek_err` are all low, and no cylinder counts as loaded.
- R2: A seek whose cylinder is at or above `cfg_cyls` raises `seek_err` for one cycle, one cycle after the command. It leaves `cur_cyl` and the buffer contents unchanged and causes no memory traffic.
- R3: A seek issued while `busy` is high raises `seek_err` one cycle later. The seek already in progress continues to its own target.
- R4: A seek to the cylinder already loaded gives `seek_done` one cycle later, with no memory traffic and no change to the buffer.
- R5: Before a load, only tracks written since the last load are copied back. Modified heads are handled lowest first, and words go in ascending order. Each copied track counts as clean afterwards.
- R6: A load reads exactly heads × words-per-track words. Word w of head h of cylinder c comes from address `cfg_base + (c*cfg_heads + h)*cfg_track_words + w`.
- R7: `ready` is low from the cycle a seek is accepted until `seek_done`. `seek_done` is a single-cycle pulse, and `ready` is high in the following cycle.
- R8: A drive-side write is taken only while `ready` is high and the head and word lie inside the configured geometry. Any other write leaves the buffer unchanged and marks nothing modified.
- R9: While `mem_req` is high and `mem_ack` has not arrived, `mem_req`, `mem_we` and `mem_addr` hold their values.
- R10: `hd_rdata` returns the word at index `hd_head*cfg_track_words + hd_word`, one clock after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Word address of cylinder 0, head 0 in backing memory |
| cfg_cyls | input | 17 | Number of cylinders in the image |
| cfg_heads | input | 6 | Number of heads (1 to 32) |
| cfg_track_words | input | 16 | 32-bit words per track |
| seek_valid | input | 1 | Seek command strobe |
| seek_cyl | input | 16 | Target cylinder |
| seek_done | output | 1 | One-cycle pulse when a seek completes |
| seek_err | output | 1 | One-cycle pulse when a seek is rejected |
| busy | output | 1 | Writeback or load in progress |
| ready | output | 1 | A cylinder is loaded and the buffer is open to the drive side |
| cur_cyl | output | 16 | Cylinder held in the buffer |
| hd_we | input | 1 | Drive-side write strobe |
| hd_head | input | 5 | Drive-side head select |
| hd_word | input | 16 | Drive-side word index within the track |
| hd_wdata | input | 32 | Drive-side write data |
| hd_rdata | output | 32 | Buffer read data, one cycle latency |
| mem_req | output | 1 | Backing memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Backing memory word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data is valid in the same cycle |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions assume the following about the inputs:
- `mem_ack` arrives only while `mem_req` is high.
- The geometry inputs stay constant throughout a seek.
- `cfg_heads * cfg_track_words` fits within the buffer depth.

The bench meets these assumptions as follows:
- Its memory responder acknowledges only an open request, after a random delay of zero to two cycles.
- It sets the geometry once, to three heads of eight words.
- It draws random drive-side writes, including heads outside the geometry, and random target cylinders, including out-of-range ones and the current one.

// File: rtl/cylbuf_pkg.sv
package cylbuf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_WB_RD,
    ST_WB_WR,
    ST_LOAD,
    ST_DONE
  } seek_st_e;
endpackage

// File: rtl/cylbuf_ram.sv
module cylbuf_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem_q[addr];
  end
endmodule

// File: rtl/cylbuf_dirty.sv
module cylbuf_dirty #(
  parameter int HEAD_W = 5,
  localparam int NH    = 1 << HEAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [HEAD_W-1:0] set_head,
  input  logic              clr_en,
  input  logic [HEAD_W-1:0] clr_head,
  output logic              any,
  output logic [HEAD_W-1:0] pick_head
);
  logic [NH-1:0] dirty_q;

  for (genvar i = 0; i < NH; i++) begin : g_bit
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_head == HEAD_W'(i));
    assign hit_clr = clr_en && (clr_head == HEAD_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dirty_q[i] <= 1'b0;
      else if (hit_set) dirty_q[i] <= 1'b1;
      else if (hit_clr) dirty_q[i] <= 1'b0;
    end
  end

  assign any = |dirty_q;

  always_comb begin
    pick_head = '0;
    for (int i = NH - 1; i >= 0; i--) begin
      if (dirty_q[i]) pick_head = HEAD_W'(i);
    end
  end

  // R5
  clr_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> dirty_q[clr_head]);

  // R5
  cleared_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && !(set_en && set_head == clr_head) |=> !dirty_q[$past(clr_head)]);
endmodule

// File: rtl/cylbuf_seek_ctrl.sv
module cylbuf_seek_ctrl
  import cylbuf_pkg::*;
#(
  parameter int CYL_W     = 16,
  parameter int HEAD_W    = 5,
  parameter int TW_W      = 16,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BUF_WORDS = 256,
  localparam int BUF_AW   = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CYL_W:0]    cfg_cyls,
  input  logic [HEAD_W:0]   cfg_heads,
  input  logic [TW_W-1:0]   cfg_track_words,
  input  logic              seek_valid,
  input  logic [CYL_W-1:0]  seek_cyl,
  output logic              seek_done,
  output logic              seek_err,
  output logic              busy,
  output logic              ready,
  output logic [CYL_W-1:0]  cur_cyl,
  input  logic              hd_we,
  input  logic [HEAD_W-1:0] hd_head,
  input  logic [TW_W-1:0]   hd_word,
  input  logic [DATA_W-1:0] hd_wdata,
  output logic [DATA_W-1:0] hd_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  // Reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  seek_st_e          st_q, st_d;
  logic [HEAD_W-1:0] head_q, head_d;
  logic [TW_W-1:0]   word_q, word_d;
  logic [CYL_W-1:0]  tgt_q, tgt_d, cur_q, cur_d;
  logic              loaded_q, loaded_d, err_q, err_d;
  logic              clr_en, load_wr, host_wr, in_range;
  logic              last_word, last_head, dirty_any;
  logic [HEAD_W-1:0] pick_head;
  logic [CYL_W-1:0]  act_cyl;
  logic [BUF_AW-1:0] ctrl_idx, host_idx, ram_addr;
  logic [DATA_W-1:0] ram_wdata, buf_q;
  logic              ram_we;

  assign busy      = (st_q != ST_IDLE);
  assign ready     = loaded_q && !busy;
  assign seek_done = (st_q == ST_DONE);
  assign seek_err  = err_q;
  assign cur_cyl   = cur_q;
  assign in_range  = {1'b0, seek_cyl} < cfg_cyls;
  assign last_word = (word_q == cfg_track_words - 1'b1);
  assign last_head = ({1'b0, head_q} == cfg_heads - 1'b1);
  assign host_wr   = hd_we && ready && ({1'b0, hd_head} < cfg_heads) &&
                     (hd_word < cfg_track_words);

  // Buffer index: head region selected by multiplying by track length
  assign ctrl_idx  = BUF_AW'(32'(head_q) * 32'(cfg_track_words) + 32'(word_q));
  assign host_idx  = BUF_AW'(32'(hd_head) * 32'(cfg_track_words) + 32'(hd_word));
  assign ram_addr  = busy ? ctrl_idx : host_idx;
  assign ram_we    = load_wr || host_wr;
  assign ram_wdata = load_wr ? mem_rdata : hd_wdata;

  // Backing address: base + (cyl*heads + head)*words + word
  assign act_cyl   = (st_q == ST_LOAD) ? tgt_q : cur_q;
  assign mem_addr  = cfg_base +
                     (ADDR_W'(act_cyl) * ADDR_W'(cfg_heads) + ADDR_W'(head_q)) *
                     ADDR_W'(cfg_track_words) + ADDR_W'(word_q);
  assign mem_wdata = buf_q;
  assign hd_rdata  = buf_q;

  cylbuf_ram #(.DATA_W(DATA_W), .DEPTH(BUF_WORDS)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(buf_q)
  );

  cylbuf_dirty #(.HEAD_W(HEAD_W)) u_dirty (
    .clk(clk), .rst_n(rst_q),
    .set_en(host_wr), .set_head(hd_head),
    .clr_en(clr_en), .clr_head(head_q),
    .any(dirty_any), .pick_head(pick_head)
  );

  always_comb begin
    st_d     = st_q;
    head_d   = head_q;
    word_d   = word_q;
    tgt_d    = tgt_q;
    cur_d    = cur_q;
    loaded_d = loaded_q;
    err_d    = seek_valid && busy;
    clr_en   = 1'b0;
    load_wr  = 1'b0;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    case (st_q)
      ST_IDLE: if (seek_valid) begin
        if (!in_range)                           err_d = 1'b1;
        else if (loaded_q && seek_cyl == cur_q)  st_d  = ST_DONE;
        else begin
          tgt_d = seek_cyl;
          st_d  = ST_SCAN;
        end
      end
      ST_SCAN: begin
        word_d = '0;
        if (dirty_any) begin
          head_d = pick_head;
          st_d   = ST_WB_RD;
        end else begin
          head_d = '0;
          st_d   = ST_LOAD;
        end
      end
      ST_WB_RD: st_d = ST_WB_WR;
      ST_WB_WR: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          if (last_word) begin
            clr_en = 1'b1;
            st_d   = ST_SCAN;
          end else begin
            word_d = word_q + 1'b1;
            st_d   = ST_WB_RD;
          end
        end
      end
      ST_LOAD: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          load_wr = 1'b1;
          if (last_word) begin
            word_d = '0;
            if (last_head) begin
              st_d     = ST_DONE;
              cur_d    = tgt_q;
              loaded_d = 1'b1;
            end else begin
              head_d = head_q + 1'b1;
            end
          end else begin
            word_d = word_q + 1'b1;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q     <= ST_IDLE;
      head_q   <= '0;
      word_q   <= '0;
      tgt_q    <= '0;
      cur_q    <= '0;
      loaded_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      head_q   <= head_d;
      word_q   <= word_d;
      loaded_q <= loaded_d;
      err_q    <= err_d;
      if (st_q == ST_IDLE) tgt_q <= tgt_d;
      if (st_q == ST_LOAD) cur_q <= cur_d;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !busy |-> !mem_req);

  // R2
  range_err_chk: assert property (@(posedge clk) disable iff (!rst_q)
    seek_valid && !busy && !in_range |=> seek_err && !busy && $stable(cur_cyl));

  // R3
  busy_err_chk: assert property (@(posedge clk) disable iff (!rst_q)
    seek_valid && busy && !seek_done |=> seek_err && $stable(tgt_q));

  // R4
  same_cyl_chk: assert property (@(posedge clk) disable iff (!rst_q)
    seek_valid && ready && in_range && seek_cyl == cur_cyl |=> seek_done && !mem_req);

  // R7
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_q)
    seek_done |=> ready && !seek_done);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr));
endmodule

// File: tb/cylbuf_seek_ctrl_bench.sv
module cylbuf_seek_ctrl_bench;
  localparam int NHD  = 3;
  localparam int TW   = 8;
  localparam int NCYL = 10;
  localparam int BASE = 64;
  localparam int CYLW = NHD * TW;
  localparam int IMG  = NCYL * CYLW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        seek_valid, seek_done, seek_err, busy, ready;
  logic [15:0] seek_cyl, cur_cyl, hd_word;
  logic [4:0]  hd_head;
  logic        hd_we, mem_req, mem_we, mem_ack;
  logic [31:0] hd_wdata, hd_rdata, mem_addr, mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  cylbuf_seek_ctrl u_cylbuf_seek_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_base(32'(BASE)), .cfg_cyls(17'(NCYL)), .cfg_heads(6'(NHD)),
    .cfg_track_words(16'(TW)),
    .seek_valid(seek_valid), .seek_cyl(seek_cyl), .seek_done(seek_done),
    .seek_err(seek_err), .busy(busy), .ready(ready), .cur_cyl(cur_cyl),
    .hd_we(hd_we), .hd_head(hd_head), .hd_word(hd_word), .hd_wdata(hd_wdata),
    .hd_rdata(hd_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [IMG];
  logic [31:0] ref_img [IMG];
  bit   dirt [NHD];
  int   nwr, nrd, last_wr, tgt, cur;
  bit   order_bad, rd_bad;

  function automatic int img_idx(int c, int h, int w);
    return (c * NHD + h) * TW + w;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Backing memory responder
  initial begin
    int dly = 0;
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (dly == 0) begin
          int a;
          a = int'(mem_addr) - BASE;
          mem_ack = 1'b1;
          if (a < 0 || a >= IMG) rd_bad = 1'b1;
          else if (mem_we) begin
            mem[a] = mem_wdata; nwr++;
            if (a <= last_wr) order_bad = 1'b1;
            last_wr = a;
          end else begin
            mem_rdata = mem[a]; nrd++;
            if (a / CYLW != tgt) rd_bad = 1'b1;
          end
          dly = int'($urandom % 3);
        end else dly--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  task automatic host_write(int h, int w, logic [31:0] d);
    @(negedge clk);
    hd_we = 1'b1; hd_head = 5'(h); hd_word = 16'(w); hd_wdata = d;
    @(negedge clk);
    hd_we = 1'b0;
  endtask

  task automatic check_buf(string req);
    int bad = 0;
    for (int h = 0; h < NHD; h++)
      for (int w = 0; w < TW; w++) begin
        hd_head = 5'(h); hd_word = 16'(w);
        @(negedge clk);
        if (hd_rdata !== ref_img[img_idx(cur, h, w)]) bad++;
      end
    check(bad == 0, req, "buffer words mismatching", bad, 0);
  endtask

  task automatic check_backing();
    int bad = 0;
    for (int i = 0; i < IMG; i++)
      if (i / CYLW != cur && mem[i] !== ref_img[i]) bad++;
    check(bad == 0, "R5", "backing words mismatching", bad, 0);
  endtask

  task automatic do_seek(int c, bit inject, output bit got_done, output bit got_err);
    nwr = 0; nrd = 0; last_wr = -1; order_bad = 0; rd_bad = 0;
    tgt = c;
    @(negedge clk);
    seek_valid = 1'b1; seek_cyl = 16'(c);
    @(negedge clk);
    seek_valid = 1'b0;
    got_err = seek_err; got_done = seek_done;
    if (!got_err && !got_done) begin
      for (int t = 0; t < 5000 && !got_done; t++) begin
        if (t == 3 && inject) begin
          check(busy && !ready, "R7", "busy/not-ready during load", ready, 0);
          seek_valid = 1'b1; seek_cyl = 16'((c + 1) % NCYL);
          hd_we = 1'b1; hd_head = 5'd0; hd_word = 16'd1; hd_wdata = 32'hDEAD_BEEF;
        end
        @(negedge clk);
        if (t == 3 && inject) begin
          seek_valid = 1'b0; hd_we = 1'b0;
          check(seek_err, "R3", "seek_err while busy", seek_err, 1);
        end
        if (seek_done) got_done = 1'b1;
      end
    end
    if (got_done) begin
      @(negedge clk);
      check(!seek_done && ready, "R7", "done pulse then ready", {seek_done, ready}, 1);
    end
  endtask

  initial begin
    bit d, e;
    void'($urandom(32'd4242));
    for (int i = 0; i < IMG; i++) begin
      mem[i] = 32'(i) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
      ref_img[i] = mem[i];
    end
    rst_n = 1'b0; seek_valid = 1'b0; seek_cyl = '0;
    hd_we = 1'b0; hd_head = '0; hd_word = '0; hd_wdata = '0;
    cur = 0; tgt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !ready && !mem_req && !seek_done && !seek_err, "R1",
          "outputs after reset", {busy, ready, mem_req, seek_done, seek_err}, 0);

    // R8: write before any load is ignored (no dirty -> no writeback later)
    host_write(0, 0, 32'h1111_2222);

    do_seek(2, 1'b0, d, e);
    cur = 2;
    check(d && !e, "R6", "first seek completes", d, 1);
    check(nrd == CYLW && !rd_bad, "R6", "load read count", nrd, CYLW);
    check(nwr == 0, "R8", "no writeback of pre-load write", nwr, 0);
    check(cur_cyl == 16'(2), "R6", "cur_cyl", cur_cyl, 2);
    check_buf("R10");

    // R3/R8: extra seek and host write while busy
    do_seek(5, 1'b1, d, e);
    cur = 5;
    check(d && cur_cyl == 16'(5), "R3", "busy seek did not redirect", cur_cyl, 5);
    check_buf("R8");

    for (int it = 0; it < 24; it++) begin
      int nw = int'($urandom % 6);
      int c;
      for (int k = 0; k < nw; k++) begin
        int h = int'($urandom % 4);
        int w = int'($urandom % 9);
        logic [31:0] v = $urandom;
        host_write(h, w, v);
        if (h < NHD && w < TW) begin
          ref_img[img_idx(cur, h, w)] = v;
          dirt[h] = 1'b1;
        end
      end
      case ($urandom % 4)
        0:       c = cur;
        1:       c = NCYL + int'($urandom % 3);
        default: c = int'($urandom % NCYL);
      endcase
      do_seek(c, 1'b0, d, e);
      if (c >= NCYL) begin
        check(e && !d, "R2", "range error", e, 1);
        check(nwr + nrd == 0 && cur_cyl == 16'(cur), "R2", "no traffic/cyl kept",
              nwr + nrd, 0);
      end else if (c == cur) begin
        check(d && nwr + nrd == 0, "R4", "same-cylinder traffic", nwr + nrd, 0);
      end else begin
        int nd = 0;
        for (int h = 0; h < NHD; h++) if (dirt[h]) nd++;
        check(d && nwr == nd * TW, "R5", "writeback word count", nwr, nd * TW);
        check(!order_bad, "R5", "writeback order", order_bad, 0);
        check(nrd == CYLW && !rd_bad, "R6", "load reads", nrd, CYLW);
        for (int h = 0; h < NHD; h++) dirt[h] = 1'b0;
        cur = c;
        check_backing();
      end
      check_buf("R10");
    end
    finish_run();
  end
endmodule